// File: doc/BRIEF.md
# Variable Count Shift Unit

This block is a purely combinational 32-bit shifter serving four shift opcodes of a load/store processor: logical right, arithmetic right, logical left and rotate left. The operand arrives from the first source register. The shift amount is chosen per instruction. A nonzero value in the low five bits of the instruction's 12-bit count/modifier field is used directly. A zero value there means the amount is read from the low five bits of a second register.

The unit sits beside the ALU in the execute stage. The opcode, the count field, the operand and the count register are fed in. The unit answers in the same cycle with the shifted word and a flag that says whether the opcode was one of its own. For any other opcode the result is forced to zero, so the result can be OR-merged onto a shared result bus. Register reads and write-back stay with the surrounding datapath.

Top module: `var_shift_unit`

## Requirements
- R1: When imm_field[4:0] is nonzero, the effective shift count equals imm_field[4:0] and cnt_reg has no effect on the result.
- R2: When imm_field[4:0] is zero, the effective shift count equals cnt_reg[4:0]. Bits 31..5 of cnt_reg have no effect.
- R3: Opcode 26 (5'b11010) shifts src_val right by the count and fills the vacated upper bits with zeros.
- R4: Opcode 27 (5'b11011) shifts src_val right by the count and fills the vacated upper bits with src_val[31]. For example, 0x97EAEC16 shifted by 13 gives 0xFFFCBF57.
- R5: Opcode 28 (5'b11100) shifts src_val left by the count and fills the vacated lower bits with zeros.
- R6: Opcode 29 (5'b11101) rotates src_val left by the count. Bits leaving at bit 31 re-enter at bit 0, so the number of set bits is preserved.
- R7: An effective count of zero (both imm_field[4:0] and cnt_reg[4:0] zero) returns src_val unchanged for all four shift opcodes.
- R8: res_ok is 1 only for opcodes 26 to 29. For every other opcode, res_ok is 0 and shift_res is 0.
- R9: Bits 11..5 of imm_field have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Instruction opcode |
| imm_field | input | 12 | Instruction count/modifier field; the low 5 bits are the immediate count |
| src_val | input | 32 | Operand value to be shifted |
| cnt_reg | input | 32 | Register value whose low 5 bits supply the count when the immediate is zero |
| shift_res | output | 32 | Shifted result, zero when the opcode is not a shift |
| res_ok | output | 1 | High when the opcode is one of the four shift opcodes |

## Verification
Count-source selection and the wrap-around of the rotate can act on the same input. The bench covers this case with a zero immediate, a rotate opcode and a count register whose upper bits carry noise. The result must then match a rotate by only the low five register bits. Noise in the upper immediate bits is combined with a live immediate count in the same way. The gating of unknown opcodes is checked while a nonzero count and a full operand are present. This shows that no shifted data leaks out.

// File: rtl/vshift_pkg.sv
// Package: shared encodings for the variable count shift unit.
// Assumes opcodes are 5 bits wide and that the four shift opcodes are fixed.
package vshift_pkg;

    localparam int OP_W = 5;

    // Opcode values the unit responds to
    typedef enum logic [OP_W-1:0] {
        OPC_SHR  = 5'd26,
        OPC_SHRA = 5'd27,
        OPC_SHL  = 5'd28,
        OPC_ROTL = 5'd29
    } shift_opc_e;

    // Internal datapath mode after decode
    typedef enum logic [1:0] {
        MODE_RIGHT_ZERO = 2'd0,
        MODE_RIGHT_SIGN = 2'd1,
        MODE_LEFT_ZERO  = 2'd2,
        MODE_LEFT_WRAP  = 2'd3
    } shift_mode_e;

endpackage

// File: rtl/vshift_count_sel.sv
// Module: vshift_count_sel
// Picks the effective shift count. A nonzero immediate wins. A zero immediate
// defers to the low bits of the count register.
// Assumes FIELD_W and DATA_W are both at least CNT_W wide.
module vshift_count_sel #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 12,
    parameter int CNT_W   = 5
) (
    input  logic [FIELD_W-1:0] imm_field,
    input  logic [DATA_W-1:0]  cnt_reg,
    output logic [CNT_W-1:0]   count
);

    logic [CNT_W-1:0] imm_cnt;
    logic             unused_hi;

    assign imm_cnt   = imm_field[CNT_W-1:0];
    assign unused_hi = ^{imm_field[FIELD_W-1:CNT_W], cnt_reg[DATA_W-1:CNT_W]};

    // Choose the immediate count unless it is zero
    always_comb begin
        if (imm_cnt != '0) count = imm_cnt;
        else               count = cnt_reg[CNT_W-1:0];
    end

endmodule

// File: rtl/vshift_decode.sv
// Module: vshift_decode
// Maps an opcode to a shift mode and flags whether it is a shift opcode.
// Assumes the fixed opcode encoding from vshift_pkg.
module vshift_decode
    import vshift_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output shift_mode_e     mode,
    output logic            hit
);

    // Decode the opcode into a mode and a hit flag
    always_comb begin
        hit  = 1'b1;
        mode = MODE_RIGHT_ZERO;
        case (op_code)
            OPC_SHR:  mode = MODE_RIGHT_ZERO;
            OPC_SHRA: mode = MODE_RIGHT_SIGN;
            OPC_SHL:  mode = MODE_LEFT_ZERO;
            OPC_ROTL: mode = MODE_LEFT_WRAP;
            default:  hit  = 1'b0;
        endcase
    end

endmodule

// File: rtl/vshift_barrel.sv
// Module: vshift_barrel
// Logarithmic barrel shifter. Stage k moves the word by 2**k places when
// count bit k is set. The mode selects the direction and the fill source:
// zero, the sign bit, or the bits rotated out of the top.
// Assumes DATA_W is a power of two and CNT_W equals log2(DATA_W).
module vshift_barrel
    import vshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  count,
    input  shift_mode_e       mode,
    output logic [DATA_W-1:0] result
);

    logic [CNT_W:0][DATA_W-1:0] lvl;
    logic                       go_left;
    logic                       sign_fill;
    logic                       wrap_en;

    assign go_left   = (mode == MODE_LEFT_ZERO) || (mode == MODE_LEFT_WRAP);
    assign sign_fill = (mode == MODE_RIGHT_SIGN) & operand[DATA_W-1];
    assign wrap_en   = (mode == MODE_LEFT_WRAP);
    assign lvl[0]    = operand;

    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        logic [DATA_W-1:0] right_v;
        logic [DATA_W-1:0] left_v;
        logic [SH-1:0]     low_fill;

        // Right move: new upper bits are zero or the sign copy
        assign right_v  = {{SH{sign_fill}}, lvl[k][DATA_W-1:SH]};
        // Left move: new lower bits are zero or the bits leaving the top
        assign low_fill = wrap_en ? lvl[k][DATA_W-1:DATA_W-SH] : '0;
        assign left_v   = {lvl[k][DATA_W-SH-1:0], low_fill};
        // Stage output: pass through unless this count bit is set
        assign lvl[k+1] = !count[k] ? lvl[k] : (go_left ? left_v : right_v);
    end

    assign result = lvl[CNT_W];

endmodule

// File: rtl/var_shift_unit.sv
// Module: var_shift_unit (top)
// Combinational shift unit for four shift opcodes. It selects the count,
// decodes the mode, runs the barrel shifter and zeroes the result for any
// opcode that is not a shift.
// Assumes DATA_W is a power of two and FIELD_W >= log2(DATA_W).
module var_shift_unit #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 12
) (
    input  logic [4:0]         op_code,
    input  logic [FIELD_W-1:0] imm_field,
    input  logic [DATA_W-1:0]  src_val,
    input  logic [DATA_W-1:0]  cnt_reg,
    output logic [DATA_W-1:0]  shift_res,
    output logic               res_ok
);

    localparam int CNT_W = $clog2(DATA_W);

    logic [CNT_W-1:0]          eff_cnt;
    vshift_pkg::shift_mode_e   mode;
    logic                      is_shift;
    logic [DATA_W-1:0]         raw_res;

    vshift_count_sel #(
        .DATA_W  (DATA_W),
        .FIELD_W (FIELD_W),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .imm_field (imm_field),
        .cnt_reg   (cnt_reg),
        .count     (eff_cnt)
    );

    vshift_decode u_dec (
        .op_code (op_code),
        .mode    (mode),
        .hit     (is_shift)
    );

    vshift_barrel #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_bar (
        .operand (src_val),
        .count   (eff_cnt),
        .mode    (mode),
        .result  (raw_res)
    );

    // Gate the result so that non-shift opcodes drive zero
    always_comb begin
        res_ok    = is_shift;
        shift_res = is_shift ? raw_res : '0;
    end

endmodule

// File: rtl/var_shift_unit_chk.sv
// Module: var_shift_unit_chk
// Port-level checks on the shift unit, attached through bind. The block has
// no clock, so the checks are immediate assertions that are re-evaluated
// whenever an input or output changes.
module var_shift_unit_chk #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 12
) (
    input logic [4:0]         op_code,
    input logic [FIELD_W-1:0] imm_field,
    input logic [DATA_W-1:0]  src_val,
    input logic [DATA_W-1:0]  cnt_reg,
    input logic [DATA_W-1:0]  shift_res,
    input logic               res_ok
);

    localparam int CNT_W = $clog2(DATA_W);

    logic imm_zero;
    logic unused_chk;

    assign imm_zero   = (imm_field[CNT_W-1:0] == '0);
    assign unused_chk = ^{imm_field[FIELD_W-1:CNT_W], cnt_reg[DATA_W-1:CNT_W]};

    // Check the output relations on every change
    always_comb begin
        p_idle_zero_r8: assert (res_ok || shift_res == '0)
            else $error("non-shift opcode produced nonzero result");
        p_zero_count_identity_r7: assert (!(res_ok && imm_zero && cnt_reg[CNT_W-1:0] == '0)
                                          || shift_res == src_val)
            else $error("zero count altered operand");
        p_rotate_keeps_ones_r6: assert (!(res_ok && op_code == 5'd29)
                                        || $countones(shift_res) == $countones(src_val))
            else $error("rotate changed bit count");
        p_sign_kept_r4: assert (!(res_ok && op_code == 5'd27)
                                || shift_res[DATA_W-1] == src_val[DATA_W-1])
            else $error("arithmetic shift lost sign");
        p_top_cleared_r3: assert (!(op_code == 5'd26 && !imm_zero) || !shift_res[DATA_W-1])
            else $error("logical right shift left top bit set");
        p_bottom_cleared_r5: assert (!(op_code == 5'd28 && !imm_zero) || !shift_res[0])
            else $error("left shift left bottom bit set");
    end

endmodule

bind var_shift_unit var_shift_unit_chk #(
    .DATA_W  (DATA_W),
    .FIELD_W (FIELD_W)
) u_chk (.*);

// File: tb/tb_var_shift_unit.sv
// Directed bench for var_shift_unit. Inputs are applied, the bench waits
// 2 ns for the combinational path and then compares against a reference
// built from the requirements.
module tb_var_shift_unit;

    logic        clk = 1'b0;
    logic [4:0]  op_code;
    logic [11:0] imm_field;
    logic [31:0] src_val;
    logic [31:0] cnt_reg;
    logic [31:0] shift_res;
    logic        res_ok;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    var_shift_unit dut (
        .op_code   (op_code),
        .imm_field (imm_field),
        .src_val   (src_val),
        .cnt_reg   (cnt_reg),
        .shift_res (shift_res),
        .res_ok    (res_ok)
    );

    // Reference result from the requirement text
    function automatic logic [31:0] ref_shift(input logic [4:0] op, input int n,
                                              input logic [31:0] x);
        case (op)
            5'd26: return x >> n;
            5'd27: return 32'($signed(x) >>> n);
            5'd28: return x << n;
            5'd29: return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] op, input logic [11:0] imm,
                         input logic [31:0] x, input logic [31:0] r);
        @(negedge clk);
        op_code = op; imm_field = imm; src_val = x; cnt_reg = r;
        #2;
    endtask

    // Idle inputs: opcode 0 must give no result (R8)
    task automatic t_reset_state();
        drive(5'd0, 12'h0, 32'h0, 32'h0);
        check("R8 idle ok", {31'd0, res_ok}, 32'd0);
        check("R8 idle res", shift_res, 32'd0);
    endtask

    // Immediate count used, register ignored (R1)
    task automatic t_imm_count();
        for (int op = 26; op <= 29; op++) begin
            drive(5'(op), 12'd7, 32'hA5C3_0F81, 32'h0000_0013);
            check("R1 imm count", shift_res, ref_shift(5'(op), 7, 32'hA5C3_0F81));
            check("R1 ok", {31'd0, res_ok}, 32'd1);
        end
    endtask

    // Zero immediate takes rc[4:0]; rc upper bits are noise (R2)
    task automatic t_reg_count();
        for (int op = 26; op <= 29; op++) begin
            drive(5'(op), 12'h000, 32'h8123_4567, 32'hDEAD_BEE9);
            check("R2 reg count", shift_res, ref_shift(5'(op), 9, 32'h8123_4567));
        end
    endtask

    // Arithmetic shift example (R4)
    task automatic t_sign_example();
        drive(5'd27, 12'd13, 32'h97EA_EC16, 32'h0);
        check("R4 example", shift_res, 32'hFFFC_BF57);
        drive(5'd27, 12'd13, 32'h17EA_EC16, 32'h0);
        check("R4 positive", shift_res, 32'h0000_BF57);
    endtask

    // Every count for every shift opcode (R3 R4 R5 R6)
    task automatic t_sweep();
        logic [31:0] pat [2] = '{32'hF00D_1235, 32'h7E5A_9C02};
        for (int p = 0; p < 2; p++)
            for (int op = 26; op <= 29; op++)
                for (int n = 1; n < 32; n++) begin
                    drive(5'(op), 12'(n), pat[p], 32'h0);
                    case (op)
                        26: check("R3 shr", shift_res, ref_shift(5'(op), n, pat[p]));
                        27: check("R4 shra", shift_res, ref_shift(5'(op), n, pat[p]));
                        28: check("R5 shl", shift_res, ref_shift(5'(op), n, pat[p]));
                        default: check("R6 rotl", shift_res, ref_shift(5'(op), n, pat[p]));
                    endcase
                end
    endtask

    // Zero effective count leaves the operand as is (R7)
    task automatic t_zero_count();
        for (int op = 26; op <= 29; op++) begin
            drive(5'(op), 12'hFE0, 32'h9BCD_EF01, 32'hFFFF_FFE0);
            check("R7 identity", shift_res, 32'h9BCD_EF01);
        end
    endtask

    // Every non-shift opcode is gated off (R8)
    task automatic t_other_ops();
        for (int op = 0; op < 32; op++) begin
            if (op >= 26 && op <= 29) continue;
            drive(5'(op), 12'd3, 32'hFFFF_FFFF, 32'h1F);
            check("R8 res zero", shift_res, 32'd0);
            check("R8 ok low", {31'd0, res_ok}, 32'd0);
        end
    endtask

    // Upper immediate bits are ignored (R9)
    task automatic t_upper_imm();
        drive(5'd29, 12'hFA5, 32'h1234_5678, 32'h0);
        check("R9 upper imm", shift_res, ref_shift(5'd29, 5, 32'h1234_5678));
        drive(5'd26, 12'hFE0, 32'h8000_0001, 32'h4);
        check("R9 upper imm zero low", shift_res, 32'h0800_0000);
    endtask

    initial begin
        op_code = '0; imm_field = '0; src_val = '0; cnt_reg = '0;
        t_reset_state();
        t_imm_count();
        t_reg_count();
        t_sign_example();
        t_sweep();
        t_zero_count();
        t_other_ops();
        t_upper_imm();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule